// File: doc/BRIEF.md
# Ring Privilege Check Unit

This unit judges, one request at a time, whether an operation may proceed under a four-ring protection scheme. Ring 0 holds the most rights and ring 3 the fewest. The unit keeps the current ring and the I/O privilege field as its own state. Each request names an operation class together with its operands: a selector ring, a descriptor ring, a new flags word, a port number, a page user bit, and the descriptor rings of the data segment registers. One cycle after the request is taken, a registered response gives an allow bit, a 3-bit fault code, the flags word after masking, and a vector of the segment registers to clear.

Requests use a valid/ready handshake. The response slot holds one entry. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the slot is empty or when the consumer takes the held response on that same edge (`rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and no request is taken.

Port checks can fall back to a per-port permission bitmap held outside the unit. The unit drives `bm_index` with the requested port. The bitmap holder must return `bm_deny` for that port and a constant `bm_limit` in the same cycle, with no delay.

Top module: `ring_guard`

## Requirements
- R1: Synchronous reset (`rst` high) sets the current ring to 0, the held I/O privilege field to 0, `rsp_valid` to 0 and `rsp_seg_clr` to all zeros.
- R2: A request is taken when `req_valid && req_ready`, with `req_ready = !rsp_valid || rsp_ready`. Its response appears with `rsp_valid` high on the next cycle and stays unchanged while `rsp_ready` is low.
- R3: Operation code 0 (privileged instruction) is allowed only in ring 0. In any other ring it faults with code 1.
- R4: Operation code 1 (flags restore) is always allowed. In ring 0 the field at bits 13:12 of `req_flags` becomes the held I/O privilege field and is passed through. In other rings `rsp_flags` carries the held field in bits 13:12, and the held field does not change.
- R5: Operation code 2 (port I/O) is allowed when the current ring is numerically at most the held I/O privilege field. Failing that, it is allowed when the port is at most `bm_limit` and `bm_deny` is 0. Otherwise it faults with code 2.
- R6: Operation code 3 (interrupt-flag change) is allowed only when the current ring is at most the held I/O privilege field, with no bitmap fallback. Otherwise it faults with code 2.
- R7: Operation code 4 (data segment load) is allowed when the larger of the current ring and `req_rpl` is at most `req_dpl`. Otherwise it faults with code 3.
- R8: Operation code 5 (page access) is allowed on a user page (`req_page_user`=1) from any ring. A supervisor page is allowed only from rings 0 to 2. Otherwise it faults with code 4.
- R9: Operation code 6 (return) takes `req_rpl` as the target ring. A target below the current ring faults with code 5 and leaves the ring unchanged. Otherwise the ring becomes the target, and `rsp_seg_clr` bit i is set exactly when segment i's descriptor ring (`req_seg_dpl[2i+1:2i]`) is below the target. Every other response carries an all-zero clear vector.
- R10: Operation code 7 is undefined and faults with code 6. An allowed response always carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_op | input | 3 | Operation class code |
| req_rpl | input | 2 | Selector ring, or target ring for a return |
| req_dpl | input | 2 | Descriptor ring of the segment being loaded |
| req_flags | input | FLAGS_W | New flags word for a flags restore |
| req_port | input | PORT_W | Port number for port I/O |
| req_page_user | input | 1 | Page user bit (1 = user page) |
| req_seg_dpl | input | 2*NSEG | Descriptor rings of the data segment registers |
| bm_index | output | PORT_W | Port looked up in the permission bitmap |
| bm_limit | input | PORT_W | Highest port the bitmap covers |
| bm_deny | input | 1 | Bitmap bit for `bm_index` (1 = denied) |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_allow | output | 1 | Operation allowed |
| rsp_cause | output | 3 | Fault code, 0 when allowed |
| rsp_flags | output | FLAGS_W | Flags word after masking |
| rsp_seg_clr | output | NSEG | Segment registers to clear |
| cur_level | output | 2 | Current ring |
| cur_iopl | output | 2 | Held I/O privilege field |

## Verification
Two things can fall in the same clock edge: the consumer taking a held response, and a new request being accepted into the freed slot. The bench first stalls `rsp_ready` with a request waiting. It checks that `req_ready` drops and that the held fault code stays fixed. It then raises `rsp_ready` while the request is still presented, so the handover happens in a single cycle. It then checks that the next response belongs to the second request and that the slot empties once `req_valid` drops. In the same way, back-to-back requests show that state changes made by a return or a ring-0 flags restore are seen by the request that follows.

// File: rtl/ring_guard_pkg.sv
package ring_guard_pkg;
  typedef logic [1:0] level_t;

  typedef enum logic [2:0] {
    OP_PRIV  = 3'd0,
    OP_FLAGS = 3'd1,
    OP_PORT  = 3'd2,
    OP_INTF  = 3'd3,
    OP_SEGLD = 3'd4,
    OP_PAGE  = 3'd5,
    OP_RET   = 3'd6,
    OP_RSVD  = 3'd7
  } ring_op_e;

  typedef enum logic [2:0] {
    CZ_NONE = 3'd0,
    CZ_PRIV = 3'd1,
    CZ_IO   = 3'd2,
    CZ_SEG  = 3'd3,
    CZ_PAGE = 3'd4,
    CZ_RET  = 3'd5,
    CZ_OP   = 3'd6
  } cause_e;

  localparam level_t LVL_KERNEL = 2'd0;
  localparam level_t LVL_OUTER  = 2'd3;
endpackage

// File: rtl/ring_io_gate.sv
module ring_io_gate
  import ring_guard_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  level_t              level,
  input  level_t              iopl,
  input  logic                bitmap_ok_op,
  input  logic [PORT_W-1:0]   port,
  input  logic [PORT_W-1:0]   limit,
  input  logic                deny_bit,
  output logic                grant
);
  logic by_field;
  logic by_bitmap;

  // Ring meets the held field, or the bitmap opens this port.
  assign by_field  = (level <= iopl);
  assign by_bitmap = bitmap_ok_op && (port <= limit) && !deny_bit;
  assign grant     = by_field || by_bitmap;
endmodule

// File: rtl/ring_seg_scrub.sv
module ring_seg_scrub
  import ring_guard_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  level_t             target,
  input  logic [2*NSEG-1:0]  seg_dpl,
  output logic [NSEG-1:0]    clr
);
  // A segment the target ring could not load itself is scrubbed.
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign clr[i] = (seg_dpl[2*i +: 2] < target);
  end
endmodule

// File: rtl/ring_guard.sv
module ring_guard
  import ring_guard_pkg::*;
#(
  parameter int FLAGS_W  = 16,
  parameter int IOPL_LSB = 12,
  parameter int PORT_W   = 8,
  parameter int NSEG     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_op,
  input  logic [1:0]          req_rpl,
  input  logic [1:0]          req_dpl,
  input  logic [FLAGS_W-1:0]  req_flags,
  input  logic [PORT_W-1:0]   req_port,
  input  logic                req_page_user,
  input  logic [2*NSEG-1:0]   req_seg_dpl,
  output logic [PORT_W-1:0]   bm_index,
  input  logic [PORT_W-1:0]   bm_limit,
  input  logic                bm_deny,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_allow,
  output logic [2:0]          rsp_cause,
  output logic [FLAGS_W-1:0]  rsp_flags,
  output logic [NSEG-1:0]     rsp_seg_clr,
  output logic [1:0]          cur_level,
  output logic [1:0]          cur_iopl
);
  localparam int IOPL_HI = IOPL_LSB + 1;

  ring_op_e           op;
  cause_e             cause;
  logic               accept;
  logic               io_grant;
  logic [NSEG-1:0]    scrub_vec;
  level_t             eff_level;
  logic [FLAGS_W-1:0] masked_flags;
  level_t             level_q;
  level_t             iopl_q;

  assign op        = ring_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign bm_index  = req_port;
  assign cur_level = level_q;
  assign cur_iopl  = iopl_q;

  ring_io_gate #(.PORT_W(PORT_W)) u_io (
    .level        (level_q),
    .iopl         (iopl_q),
    .bitmap_ok_op (op == OP_PORT),
    .port         (req_port),
    .limit        (bm_limit),
    .deny_bit     (bm_deny),
    .grant        (io_grant)
  );

  ring_seg_scrub #(.NSEG(NSEG)) u_scrub (
    .target  (req_rpl),
    .seg_dpl (req_seg_dpl),
    .clr     (scrub_vec)
  );

  assign eff_level = (req_rpl > level_q) ? req_rpl : level_q;

  always_comb begin
    masked_flags = req_flags;
    if (level_q != LVL_KERNEL) masked_flags[IOPL_HI:IOPL_LSB] = iopl_q;
  end

  always_comb begin
    cause = CZ_NONE;
    case (op)
      OP_PRIV:  if (level_q != LVL_KERNEL) cause = CZ_PRIV;
      OP_FLAGS: cause = CZ_NONE;
      OP_PORT,
      OP_INTF:  if (!io_grant) cause = CZ_IO;
      OP_SEGLD: if (eff_level > req_dpl) cause = CZ_SEG;
      OP_PAGE:  if (!req_page_user && level_q == LVL_OUTER) cause = CZ_PAGE;
      OP_RET:   if (req_rpl < level_q) cause = CZ_RET;
      default:  cause = CZ_OP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_allow   <= 1'b0;
      rsp_cause   <= 3'd0;
      rsp_flags   <= '0;
      rsp_seg_clr <= '0;
      level_q     <= LVL_KERNEL;
      iopl_q      <= LVL_KERNEL;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_allow   <= (cause == CZ_NONE);
      rsp_cause   <= cause;
      rsp_flags   <= masked_flags;
      rsp_seg_clr <= (op == OP_RET && cause == CZ_NONE) ? scrub_vec : '0;
      if (op == OP_FLAGS && level_q == LVL_KERNEL)
        iopl_q <= req_flags[IOPL_HI:IOPL_LSB];
      if (op == OP_RET && cause == CZ_NONE)
        level_q <= req_rpl;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Held response does not move while the consumer stalls.
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cause) && $stable(rsp_allow));

  // Privileged class outside ring 0 always produces a fault.
  assert_priv_R3: assert property (@(posedge clk) disable iff (rst)
    accept && op == OP_PRIV && level_q != LVL_KERNEL |=> !rsp_allow && rsp_cause == 3'd1);

  // Outside ring 0 a flags restore never moves the held field.
  assert_iopl_keep_R4: assert property (@(posedge clk) disable iff (rst)
    accept && op == OP_FLAGS && level_q != LVL_KERNEL |=> $stable(cur_iopl));

  // Only a return changes the ring.
  assert_level_R9: assert property (@(posedge clk) disable iff (rst)
    accept && op != OP_RET |=> $stable(cur_level));

  // A faulted response never scrubs segments.
  assert_clr_fault_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_allow |-> rsp_seg_clr == '0);

  // Allow and fault code agree.
  assert_code_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow == (rsp_cause == 3'd0)));
endmodule

// File: tb/ring_guard_test.sv
module ring_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // op[28:26] rpl[25:24] dpl[23:22] port[21:14] user[13] deny[12]
  // new_iopl[11:10] exp_flags_iopl[9:8] exp_allow[7] exp_cause[6:4] exp_clr[3:0]
  localparam logic [28:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R3 ring0 priv
    {3'd1, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd2, 2'd2, 1'b1, 3'd0, 4'b0000}, // R4 ring0 flags
    {3'd2, 2'd0, 2'd0, 8'h50, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R5 field grants
    {3'd4, 2'd1, 2'd1, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R7 equal
    {3'd4, 2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd3, 4'b0000}, // R7 rpl too weak
    {3'd5, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R8 sup page ring0
    {3'd6, 2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0111}, // R9 return to 3
    {3'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd1, 4'b0000}, // R3 ring3 priv
    {3'd2, 2'd0, 2'd0, 8'h05, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R5 bitmap grants
    {3'd2, 2'd0, 2'd0, 8'h05, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 3'd2, 4'b0000}, // R5 bitmap denies
    {3'd2, 2'd0, 2'd0, 8'h50, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd2, 4'b0000}, // R5 beyond limit
    {3'd2, 2'd0, 2'd0, 8'h3F, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R5 at limit
    {3'd3, 2'd0, 2'd0, 8'h05, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd2, 4'b0000}, // R6 no fallback
    {3'd5, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd4, 4'b0000}, // R8 sup page ring3
    {3'd5, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R8 user page
    {3'd4, 2'd0, 2'd3, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 4'b0000}, // R7 ring3 dpl3
    {3'd4, 2'd0, 2'd2, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd3, 4'b0000}, // R7 ring dominates
    {3'd1, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd3, 2'd2, 1'b1, 3'd0, 4'b0000}, // R4 masked
    {3'd3, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd2, 4'b0000}, // R4/R6 field kept
    {3'd6, 2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd5, 4'b0000}, // R9 inward
    {3'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd1, 4'b0000}, // R9 ring kept
    {3'd7, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd6, 4'b0000}  // R10 undefined
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [1:0]  req_rpl = 2'd0;
  logic [1:0]  req_dpl = 2'd0;
  logic [15:0] req_flags = 16'h0;
  logic [7:0]  req_port = 8'h0;
  logic        req_page_user = 1'b0;
  logic [7:0]  req_seg_dpl = {2'd3, 2'd2, 2'd1, 2'd0};
  logic [7:0]  bm_index;
  logic [7:0]  bm_limit = 8'h3F;
  logic        bm_deny = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;
  logic [2:0]  rsp_cause;
  logic [15:0] rsp_flags;
  logic [3:0]  rsp_seg_clr;
  logic [1:0]  cur_level;
  logic [1:0]  cur_iopl;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rpl(req_rpl), .req_dpl(req_dpl), .req_flags(req_flags),
    .req_port(req_port), .req_page_user(req_page_user), .req_seg_dpl(req_seg_dpl),
    .bm_index(bm_index), .bm_limit(bm_limit), .bm_deny(bm_deny),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_allow(rsp_allow),
    .rsp_cause(rsp_cause), .rsp_flags(rsp_flags), .rsp_seg_clr(rsp_seg_clr),
    .cur_level(cur_level), .cur_iopl(cur_iopl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] rpl, input logic [1:0] dpl,
                      input logic [7:0] port, input logic user, input logic deny,
                      input logic [1:0] niopl);
    @(negedge clk);
    req_op = op; req_rpl = rpl; req_dpl = dpl; req_port = port;
    req_page_user = user; bm_deny = deny;
    req_flags = {2'b00, niopl, 12'h0A5};
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 level", cur_level, 0);
    check("R1 iopl", cur_iopl, 0);
    check("R1 valid", rsp_valid, 0);
    check("R1 clr", rsp_seg_clr, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      send(v[28:26], v[25:24], v[23:22], v[21:14], v[13], v[12], v[11:10]);
      check($sformatf("R2 valid v%0d", i), rsp_valid, 1);
      check($sformatf("R3-R10 allow v%0d", i), rsp_allow, v[7]);
      check($sformatf("R10 cause v%0d", i), rsp_cause, v[6:4]);
      check($sformatf("R9 clr v%0d", i), rsp_seg_clr, v[3:0]);
      if (v[28:26] == 3'd1) begin
        check($sformatf("R4 flags field v%0d", i), rsp_flags[13:12], v[9:8]);
        check($sformatf("R4 flags low v%0d", i), rsp_flags[11:0], 12'h0A5);
      end
    end
    check("R9 ring after inward", cur_level, 3);
    check("R4 held field", cur_iopl, 2);

    // Reset after activity.
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 level again", cur_level, 0);
    check("R1 iopl again", cur_iopl, 0);
    check("R1 clr again", rsp_seg_clr, 0);
    check("R1 valid again", rsp_valid, 0);
    rst = 1'b0;

    // Return to ring 2 from ring 0.
    send(3'd6, 2'd2, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0);
    check("R9 clr to ring2", rsp_seg_clr, 4'b0011);
    check("R9 ring2", cur_level, 2);
    send(3'd5, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0);
    check("R8 sup page ring2", rsp_allow, 1);
    check("R9 clr zero non-return", rsp_seg_clr, 0);

    // Back-pressure and same-cycle handover.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 3'd0; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 valid stalled", rsp_valid, 1);
    check("R2 ready low", req_ready, 0);
    check("R3 ring2 priv", rsp_cause, 1);
    req_op = 3'd7;
    @(posedge clk); @(negedge clk);
    check("R2 held cause", rsp_cause, 1);
    check("R2 still valid", rsp_valid, 1);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R2 handover valid", rsp_valid, 1);
    check("R10 handover cause", rsp_cause, 6);
    @(posedge clk); @(negedge clk);
    check("R2 drained", rsp_valid, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule